// File: doc/BRIEF.md
# Pattern Lookup Trigger with Prompt and Wait Windows

The block watches a set of hit channels and makes a trigger decision from the combination of channels that fired. The decision is an arbitrary programmable function of the hit pattern. It is not a threshold. The first hit seen while the block is idle opens a prompt window of programmable length. While the window is open, every hit is OR-ed into a pattern register with one bit per channel. When the window closes, the pattern is used as the address of a one-bit-wide lookup memory. The stored bit decides whether the pattern is a valid trigger.

After each decision the block enters a wait window of programmable length. During that window it ignores its inputs. When the wait window ends, the pattern is cleared and the block re-arms. A qualifying decision produces a one-cycle trigger pulse and increments an event counter. The last captured pattern stays visible on an output for readout.

The lookup memory is loaded one bit at a time through a 32-bit control word. The production configuration uses 16 channels, which gives a 65536-entry memory. The default parameter keeps the memory small.

Top module: `plt_trigger`

## Requirements
- R1: During and directly after reset, `trigPulse` is 0, `trigCount` is 0 and `promptPattern` is 0, and the block is idle.
- R2: Let a nonzero `hitIn` be sampled while idle at clock edge k. It opens the prompt window. The pattern becomes the OR of `hitIn` sampled at edges k through k+P-1, where P is `promptLen`. A `promptLen` of 0 acts as 1.
- R3: The memory is read at the final pattern at edge k+P. If the stored bit is 1 and the trigger is enabled, `trigPulse` is high for exactly the one cycle after edge k+P+1.
- R4: When `trigEnable` is 0 at edge k+P+1, no pulse is produced and the counter does not change.
- R5: `trigCount` increments by one in the same cycle as each trigger pulse, and it holds its value otherwise.
- R6: After edge k+P+1, the block ignores `hitIn` for `waitLen`+1 edges. At the last of those edges the pattern is cleared and the block returns to idle. `promptPattern` does not change during the wait.
- R7: When control word bit 30 (write strobe) is 1 at an edge, memory entry `lutCtl[CH-1:0]` takes the value of bit 16. Later lookups see the new value. A lookup at the same edge as the write reads the old value.
- R8: Control word bit 31 has no effect. A word with bit 31 set and bit 30 clear changes no memory entry.
- R9: `promptPattern` shows the pattern register at all times: it accumulates during the prompt window, holds through the read, pulse and wait, and reads 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hitIn | input | CH | Per-channel hit flags |
| lutCtl | input | 32 | Memory control word: [15:0] address, [16] data, [30] write strobe, [31] reserved |
| promptLen | input | 8 | Prompt window length in cycles |
| waitLen | input | 8 | Wait window length in cycles |
| trigEnable | input | 1 | Allows a lookup hit to fire the trigger |
| trigPulse | output | 1 | One-cycle trigger pulse |
| promptPattern | output | CH | Captured hit pattern |
| trigCount | output | CNTW | Trigger counter |

## Verification
The hardest case to reach is the collision between a memory write and the lookup that reads the same entry. The write has to arrive exactly on the read edge. The bench reaches it with a one-cycle prompt window: it drives the hit in one cycle and the conflicting write strobe in the next. It then checks that this lookup uses the old bit and that the following lookup uses the new one.

A behavioural reference model is compared with the outputs on every cycle. Sparse random hit traffic arrives during prompt and wait windows. The window lengths include 0, 1 and longer values, which exercises the window boundaries.

// File: rtl/plt_pkg.sv
package plt_pkg;
  localparam int LUT_DATA_BIT = 16;
  localparam int LUT_WE_BIT   = 30;
  localparam int LUT_RSV_BIT  = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROMPT, ST_READ, ST_FIRE, ST_WAIT
  } pltState_e;

  typedef struct packed {
    logic capture;
    logic accumulate;
    logic readLut;
    logic fire;
    logic clear;
  } pltStrb_t;
endpackage

// File: rtl/plt_ctrl.sv
module plt_ctrl
  import plt_pkg::*;
#(
  parameter int WINW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            anyHit,
  input  logic [WINW-1:0] promptLen,
  input  logic [WINW-1:0] waitLen,
  output pltStrb_t        strb
);
  pltState_e       state;
  logic [WINW-1:0] remain;
  logic [WINW-1:0] waitCnt;

  always_comb begin
    strb            = '0;
    strb.capture    = (state == ST_IDLE) && anyHit;
    strb.accumulate = (state == ST_PROMPT);
    strb.readLut    = (state == ST_READ);
    strb.fire       = (state == ST_FIRE);
    strb.clear      = (state == ST_WAIT) && (waitCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      remain  <= '0;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (anyHit) begin
          if (promptLen <= WINW'(1)) state <= ST_READ;
          else begin
            state  <= ST_PROMPT;
            remain <= promptLen - WINW'(1);
          end
        end
        ST_PROMPT: begin
          if (remain <= WINW'(1)) state <= ST_READ;
          remain <= remain - WINW'(1);
        end
        ST_READ: state <= ST_FIRE;
        ST_FIRE: begin
          waitCnt <= waitLen;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_IDLE;
          else waitCnt <= waitCnt - WINW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_strb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  assert_read_then_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.readLut |=> strb.fire);
  assert_fire_enters_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fire |=> (state == ST_WAIT) && !strb.capture && !strb.accumulate);
  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && waitCnt != '0) |=> (state == ST_WAIT));
endmodule

// File: rtl/plt_dpath.sv
module plt_dpath
  import plt_pkg::*;
#(
  parameter int CH   = 8,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH-1:0]   hitIn,
  input  logic [31:0]     lutCtl,
  input  logic            trigEnable,
  input  pltStrb_t        strb,
  output logic [CH-1:0]   pattern,
  output logic            trigPulse,
  output logic [CNTW-1:0] trigCount
);
  localparam int DEPTH = 1 << CH;

  logic lutMem [DEPTH];
  logic rdBit;

  always_ff @(posedge clk) begin
    if (lutCtl[LUT_WE_BIT]) lutMem[lutCtl[CH-1:0]] <= lutCtl[LUT_DATA_BIT];
  end

  for (genvar c = 0; c < CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n || strb.clear) pattern[c] <= 1'b0;
      else if (strb.capture)    pattern[c] <= hitIn[c];
      else if (strb.accumulate) pattern[c] <= pattern[c] | hitIn[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdBit     <= 1'b0;
      trigPulse <= 1'b0;
      trigCount <= '0;
    end else begin
      if (strb.readLut) rdBit <= lutMem[pattern];
      trigPulse <= strb.fire && rdBit && trigEnable;
      if (strb.fire && rdBit && trigEnable) trigCount <= trigCount + CNTW'(1);
    end
  end

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);
  assert_enable_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(trigEnable) |-> !trigPulse);
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> trigCount == $past(trigCount) + CNTW'(1));
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trigPulse |-> trigCount == $past(trigCount));
endmodule

// File: rtl/plt_trigger.sv
module plt_trigger
  import plt_pkg::*;
#(
  parameter int CH   = 8,
  parameter int CNTW = 32,
  parameter int WINW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH-1:0]   hitIn,
  input  logic [31:0]     lutCtl,
  input  logic [WINW-1:0] promptLen,
  input  logic [WINW-1:0] waitLen,
  input  logic            trigEnable,
  output logic            trigPulse,
  output logic [CH-1:0]   promptPattern,
  output logic [CNTW-1:0] trigCount
);
  pltStrb_t strb;

  plt_ctrl #(.WINW(WINW)) ctrl_i (
    .clk, .rst_n, .anyHit(|hitIn), .promptLen, .waitLen, .strb
  );

  plt_dpath #(.CH(CH), .CNTW(CNTW)) dpath_i (
    .clk, .rst_n, .hitIn, .lutCtl, .trigEnable, .strb,
    .pattern(promptPattern), .trigPulse, .trigCount
  );
endmodule

// File: tb/plt_trigger_tb.sv
`timescale 1ns/1ps
module plt_trigger_tb_top;
  localparam int CH = 8;
  localparam int CNTW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0] hitIn = '0;
  logic [31:0] lutCtl = '0;
  logic [7:0] promptLen = 8'd1;
  logic [7:0] waitLen = 8'd0;
  logic trigEnable = 1'b0;
  logic trigPulse;
  logic [CH-1:0] promptPattern;
  logic [CNTW-1:0] trigCount;

  int total = 0;
  int bad = 0;
  bit compareOn = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  plt_trigger #(.CH(CH), .CNTW(CNTW), .WINW(8)) dut_i (
    .clk, .rst_n, .hitIn, .lutCtl, .promptLen, .waitLen, .trigEnable,
    .trigPulse, .promptPattern, .trigCount
  );

  // behavioural reference: phase 0 idle, 1 prompt, 2 read, 3 fire, 4 wait
  bit mMem [256];
  int mPhase = 0, mLeft = 0, mWait = 0;
  int mPat = 0, mCount = 0;
  bit mRd = 0, mPulse = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; mPat = 0; mCount = 0; mRd = 0; mPulse = 0;
    end else begin
      mPulse = 0;
      case (mPhase)
        0: if (hitIn != 0) begin
             mPat = int'(hitIn);
             mLeft = (promptLen == 0) ? 0 : int'(promptLen) - 1;
             mPhase = (mLeft == 0) ? 2 : 1;
           end
        1: begin
             mPat = mPat | int'(hitIn);
             mLeft--;
             if (mLeft == 0) mPhase = 2;
           end
        2: begin mRd = mMem[mPat]; mPhase = 3; end
        3: begin
             mPulse = mRd && trigEnable;
             if (mPulse) mCount++;
             mWait = int'(waitLen);
             mPhase = 4;
           end
        default: if (mWait == 0) begin mPat = 0; mPhase = 0; end
                 else mWait--;
      endcase
      if (lutCtl[30]) mMem[lutCtl[CH-1:0]] = lutCtl[16];
    end
  end

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compareOn) begin
    check("R3 trigPulse", trigPulse, mPulse);
    check("R5 trigCount", trigCount, mCount);
    check("R9 promptPattern", promptPattern, mPat);
  end

  task automatic lutWrite(int addr, bit val);
    @(negedge clk);
    lutCtl = (32'h1 << 30) | (32'(val) << 16) | 32'(addr);
    @(negedge clk);
    lutCtl = '0;
  endtask

  task automatic pulseHit(int pat, int settle);
    @(negedge clk);
    hitIn = CH'(pat);
    @(negedge clk);
    hitIn = '0;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pulse", trigPulse, 0);
    check("R1 count", trigCount, 0);
    check("R1 pattern", promptPattern, 0);
    rst_n = 1'b1;
    compareOn = 1'b1;
    @(negedge clk);
    check("R1 idle pattern", promptPattern, 0);

    for (int a = 0; a < 256; a++) lutWrite(a, bit'($countones(a) % 2));

    trigEnable = 1'b1;
    // random traffic across window settings, including 0 and 1
    for (int cfg = 0; cfg < 6; cfg++) begin
      promptLen = 8'(cfg * 2);
      waitLen   = 8'((cfg % 3) * 3);
      for (int n = 0; n < 600; n++) begin
        @(negedge clk);
        hitIn = ($urandom % 5 == 0) ? CH'($urandom) : '0;
      end
      hitIn = '0;
      repeat (40) @(negedge clk);
    end

    // R2: hits on both ends of a 4-cycle window accumulate
    promptLen = 8'd4; waitLen = 8'd3;
    @(negedge clk); hitIn = 8'h01;
    @(negedge clk); hitIn = 8'h00;
    @(negedge clk); hitIn = 8'h00;
    @(negedge clk); hitIn = 8'h80;
    @(negedge clk); hitIn = 8'h40;
    @(negedge clk); hitIn = '0;
    check("R2 window pattern", promptPattern, 8'h81);
    repeat (12) @(negedge clk);

    // R4: enable low blocks an odd-parity pattern
    begin
      longint c0;
      trigEnable = 1'b0; promptLen = 8'd1; waitLen = 8'd0;
      c0 = trigCount;
      pulseHit(8'h01, 8);
      check("R4 no count when disabled", trigCount, c0);
      trigEnable = 1'b1;
    end

    // R6: hit in the wait window leaves pattern unchanged
    promptLen = 8'd1; waitLen = 8'd10;
    pulseHit(8'h05, 3);
    hitIn = 8'h0A;
    @(negedge clk);
    check("R6 pattern held in wait", promptPattern, 8'h05);
    hitIn = '0;
    repeat (15) @(negedge clk);
    check("R6 cleared after wait", promptPattern, 0);

    // R8: reserved bit alone writes nothing
    begin
      longint c0;
      waitLen = 8'd0;
      lutWrite(5, 1'b1);
      @(negedge clk); lutCtl = 32'h8000_0005;
      @(negedge clk); lutCtl = '0;
      c0 = trigCount;
      pulseHit(8'h05, 6);
      check("R8 entry kept", trigCount, c0 + 1);
    end

    // R7: write colliding with the read edge; old bit seen first
    begin
      longint c0;
      lutWrite(6, 1'b1);
      c0 = trigCount;
      @(negedge clk); hitIn = 8'h06;
      @(negedge clk); hitIn = '0; lutCtl = (32'h1 << 30) | 32'h6;
      @(negedge clk); lutCtl = '0;
      repeat (6) @(negedge clk);
      check("R7 collision reads old", trigCount, c0 + 1);
      pulseHit(8'h06, 6);
      check("R7 new value used", trigCount, c0 + 1);
    end

    compareOn = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule